// File: doc/BRIEF.md
# UART interrupt, control and status register block

This block is the software-visible register file of a UART. It sits on a simple 32-bit register bus and holds six things: the interrupt state, the interrupt enables, a write-only interrupt test port, the control word, the status flags and the last received byte. Four level interrupt lines leave the block. Each line is the AND of one state bit and its enable bit. State bits are set by one-cycle event pulses from the transmit FIFO and the receiver, or by software through the test port. Software clears them by writing ones to the state register.

The block is decoded by word index from a byte address inside a 1 KB window. Only aligned accesses with all four byte enables set are accepted. A rejected write changes nothing, a rejected read returns zero, and an index that has no register also reads as zero. Read data is registered: it appears on `rdata_o` on the clock edge that samples the request, and it holds until the next read.

The control word goes out whole on `ctrl_o` for the neighbouring serial blocks. A write to the transmit-data word shows up as a single-cycle push strobe carrying the low byte. The receiver hands over bytes with a valid pulse. The low four status flags are copied every cycle from the FIFO and shifter status inputs.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset the status word (index 4) reads 0x3C. The interrupt state (index 0), enable (index 1), control (index 3) and received byte (index 5) read zero, and `irq_o` is zero.
- R2: `irq_o[i]` is high exactly when state bit i and enable bit i are both set. Bit order: 0 transmit watermark, 1 receive watermark, 2 transmit empty, 3 receive overflow. Enable is written at index 1.
- R3: A write to index 0 clears each state bit whose write-data bit is one and leaves the other state bits unchanged.
- R4: A write to index 2 sets each state bit whose write-data bit is one. Reading index 2 returns zero.
- R5: When `evt_i[i]` pulses in the same cycle as a write that clears state bit i, the bit ends up set.
- R6: A byte on `rx_byte_i` with `rx_valid_i` high is stored as the received byte when control bit 1 (receive enable) is set. It then clears status bit 4 (receive idle) and status bit 5 (receive empty). With receive disabled, the byte and the status are left unchanged.
- R7: An accepted read of index 5 with receive enabled sets status bits 4 and 5 again. A byte arriving in the same cycle wins and leaves them cleared. With receive disabled, the read leaves them unchanged.
- R8: Writes to status (index 4), received byte (index 5) and line value (index 7) change nothing. Index 7 reads `line_i`. A write to index 6 raises `tx_wr_o` in that cycle with `tx_data_o` equal to write-data bits 7:0, and index 6 reads zero.
- R9: An access with `be_i` other than 4'hF, or with address bits 1:0 non-zero, is rejected: a write has no effect and a read returns zero. A read of an index above 7 returns zero.
- R10: Status bits 3:0 (transmit full, receive full, transmit empty, transmit idle) equal `hw_stat_i` as sampled on the previous clock edge.
- R11: `rdata_o` takes the value of the word read on the clock edge that samples a read request, uses the register contents from before that edge, and holds between reads.
- R12: The control word written at index 3 reads back unchanged and drives `ctrl_o` from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables, must be all ones |
| addr_i | input | 10 | Byte address in the 1 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_i | input | 4 | Interrupt event pulses from the FIFO and receiver |
| rx_valid_i | input | 1 | Received byte valid pulse |
| rx_byte_i | input | 8 | Received byte |
| hw_stat_i | input | 4 | Transmit/receive FIFO and idle flags |
| line_i | input | 2 | Sampled serial line levels |
| irq_o | output | 4 | Level interrupt lines |
| ctrl_o | output | 32 | Control word |
| tx_wr_o | output | 1 | Transmit push strobe |
| tx_data_o | output | 8 | Byte to push |

## Verification
Two pairs of events can land on the same clock edge. A hardware event pulse can meet a software clear of the same state bit. A received byte can meet a read of the received-byte word. The bench provokes both by holding `evt_i` or `rx_valid_i` high during the cycle that carries the bus request. A behavioural model applies the stated priority: the set wins, and the arrival keeps the idle and empty flags clear. Later reads of the state and status words show which side won, and the model is compared against every output on every cycle.

// File: rtl/uart_irq_regs_pkg.sv
`timescale 1ns/1ps
package uart_irq_regs_pkg;
   // word indices (byte address bits above the two alignment bits)
   localparam int unsigned IDX_STATE  = 0;
   localparam int unsigned IDX_ENABLE = 1;
   localparam int unsigned IDX_TEST   = 2;
   localparam int unsigned IDX_CTRL   = 3;
   localparam int unsigned IDX_STATUS = 4;
   localparam int unsigned IDX_RBYTE  = 5;
   localparam int unsigned IDX_TXPUSH = 6;
   localparam int unsigned IDX_LINE   = 7;
   localparam int unsigned NUM_WORDS  = 8;

   // interrupt source order
   typedef enum int unsigned {
      SRC_TX_WM  = 0,
      SRC_RX_WM  = 1,
      SRC_TX_MT  = 2,
      SRC_RX_OVF = 3
   } irq_src_e;

   // control bits consumed inside the block
   localparam int unsigned CTRL_TX_ON = 0;
   localparam int unsigned CTRL_RX_ON = 1;
endpackage

// File: rtl/uart_reg_decode.sv
`timescale 1ns/1ps
module uart_reg_decode #(
   parameter int unsigned AW        = 10,
   parameter int unsigned DW        = 32,
   parameter int unsigned NUM_WORDS = 8
) (
   input  logic                 req_i,
   input  logic                 we_i,
   input  logic [DW/8-1:0]      be_i,
   input  logic [AW-1:0]        addr_i,
   output logic [NUM_WORDS-1:0] wr_hit_o,
   output logic [NUM_WORDS-1:0] rd_hit_o,
   output logic                 rd_req_o
);
   localparam int unsigned BE_W  = DW / 8;
   localparam int unsigned IDX_W = AW - 2;

   logic accept;
   assign accept   = req_i && (be_i == {BE_W{1'b1}}) && (addr_i[1:0] == 2'b00);
   assign rd_req_o = req_i && !we_i;

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_hit
      logic sel;
      assign sel         = accept && (addr_i[AW-1:2] == IDX_W'(k));
      assign wr_hit_o[k] = sel && we_i;
      assign rd_hit_o[k] = sel && !we_i;
   end
endmodule

// File: rtl/uart_irq_bank.sv
`timescale 1ns/1ps
module uart_irq_bank #(
   parameter int unsigned NUM_IRQ = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_state_i,
   input  logic               wr_enable_i,
   input  logic               wr_test_i,
   input  logic [NUM_IRQ-1:0] wdata_i,
   input  logic [NUM_IRQ-1:0] evt_i,
   output logic [NUM_IRQ-1:0] state_o,
   output logic [NUM_IRQ-1:0] enable_o,
   output logic [NUM_IRQ-1:0] irq_o
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
      logic st_q;
      logic en_q;
      logic set_now;
      logic clr_now;

      assign set_now = evt_i[i] || (wr_test_i && wdata_i[i]);
      assign clr_now = wr_state_i && wdata_i[i];

      // a set of any origin outranks the software clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            st_q <= 1'b0;
         end else if (set_now) begin
            st_q <= 1'b1;
         end else if (clr_now) begin
            st_q <= 1'b0;
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_q <= 1'b0;
         end else if (wr_enable_i) begin
            en_q <= wdata_i[i];
         end
      end

      assign state_o[i]  = st_q;
      assign enable_o[i] = en_q;
      assign irq_o[i]    = st_q & en_q;
   end
endmodule

// File: rtl/uart_rx_status.sv
`timescale 1ns/1ps
module uart_rx_status #(
   parameter int unsigned       STAT_W   = 6,
   parameter int unsigned       BYTE_W   = 8,
   parameter logic [STAT_W-1:0] STAT_RST = 6'h3C
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [STAT_W-3:0] hw_stat_i,
   input  logic              rx_valid_i,
   input  logic [BYTE_W-1:0] rx_byte_i,
   input  logic              rx_on_i,
   input  logic              rd_rbyte_i,
   output logic [STAT_W-1:0] status_o,
   output logic [BYTE_W-1:0] rbyte_o
);
   localparam int unsigned HW_W = STAT_W - 2;

   logic [HW_W-1:0]   hw_q;
   logic [1:0]        rxflag_q;   // [0] receive idle, [1] receive empty
   logic [BYTE_W-1:0] rbyte_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hw_q <= STAT_RST[HW_W-1:0];
      end else begin
         hw_q <= hw_stat_i;
      end
   end

   // an arriving byte outranks the re-arm caused by a read
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rxflag_q <= STAT_RST[STAT_W-1:HW_W];
         rbyte_q  <= '0;
      end else if (rx_on_i && rx_valid_i) begin
         rxflag_q <= 2'b00;
         rbyte_q  <= rx_byte_i;
      end else if (rx_on_i && rd_rbyte_i) begin
         rxflag_q <= 2'b11;
      end
   end

   assign status_o = {rxflag_q, hw_q};
   assign rbyte_o  = rbyte_q;
endmodule

// File: rtl/uart_irq_regs.sv
`timescale 1ns/1ps
module uart_irq_regs
   import uart_irq_regs_pkg::*;
#(
   parameter int unsigned       AW       = 10,
   parameter int unsigned       DW       = 32,
   parameter int unsigned       NUM_IRQ  = 4,
   parameter int unsigned       STAT_W   = 6,
   parameter int unsigned       BYTE_W   = 8,
   parameter int unsigned       LINE_W   = 2,
   parameter logic [STAT_W-1:0] STAT_RST = 6'h3C,
   parameter bit                READ_REG = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_i,
   input  logic               we_i,
   input  logic [DW/8-1:0]    be_i,
   input  logic [AW-1:0]      addr_i,
   input  logic [DW-1:0]      wdata_i,
   output logic [DW-1:0]      rdata_o,
   input  logic [NUM_IRQ-1:0] evt_i,
   input  logic               rx_valid_i,
   input  logic [BYTE_W-1:0]  rx_byte_i,
   input  logic [STAT_W-3:0]  hw_stat_i,
   input  logic [LINE_W-1:0]  line_i,
   output logic [NUM_IRQ-1:0] irq_o,
   output logic [DW-1:0]      ctrl_o,
   output logic               tx_wr_o,
   output logic [BYTE_W-1:0]  tx_data_o
);
   // elaboration-time parameter checks
   if (DW != 32) begin : g_bad_dw
      $error("uart_irq_regs: DW must be 32");
   end
   if (AW < 5 || AW > 10) begin : g_bad_aw
      $error("uart_irq_regs: AW must cover 8 words inside 1 KB");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > DW) begin : g_bad_irq
      $error("uart_irq_regs: NUM_IRQ out of range");
   end
   if (STAT_W != 6) begin : g_bad_stat
      $error("uart_irq_regs: STAT_W must be 6");
   end
   if (BYTE_W > DW || LINE_W > DW) begin : g_bad_byte
      $error("uart_irq_regs: field wider than the bus");
   end

   logic [NUM_WORDS-1:0] wr_hit;
   logic [NUM_WORDS-1:0] rd_hit;
   logic                 rd_req;
   logic [NUM_IRQ-1:0]   state_q;
   logic [NUM_IRQ-1:0]   enable_q;
   logic [STAT_W-1:0]    status_q;
   logic [BYTE_W-1:0]    rbyte_q;
   logic [DW-1:0]        ctrl_q;
   logic [DW-1:0]        word_val [NUM_WORDS];
   logic [DW-1:0]        rd_val;

   uart_reg_decode #(
      .AW        (AW),
      .DW        (DW),
      .NUM_WORDS (NUM_WORDS)
   ) u_dec (
      .req_i    (req_i),
      .we_i     (we_i),
      .be_i     (be_i),
      .addr_i   (addr_i),
      .wr_hit_o (wr_hit),
      .rd_hit_o (rd_hit),
      .rd_req_o (rd_req)
   );

   uart_irq_bank #(
      .NUM_IRQ (NUM_IRQ)
   ) u_irq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_state_i  (wr_hit[IDX_STATE]),
      .wr_enable_i (wr_hit[IDX_ENABLE]),
      .wr_test_i   (wr_hit[IDX_TEST]),
      .wdata_i     (wdata_i[NUM_IRQ-1:0]),
      .evt_i       (evt_i),
      .state_o     (state_q),
      .enable_o    (enable_q),
      .irq_o       (irq_o)
   );

   uart_rx_status #(
      .STAT_W   (STAT_W),
      .BYTE_W   (BYTE_W),
      .STAT_RST (STAT_RST)
   ) u_rx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hw_stat_i  (hw_stat_i),
      .rx_valid_i (rx_valid_i),
      .rx_byte_i  (rx_byte_i),
      .rx_on_i    (ctrl_q[CTRL_RX_ON]),
      .rd_rbyte_i (rd_hit[IDX_RBYTE]),
      .status_o   (status_q),
      .rbyte_o    (rbyte_q)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
      end else if (wr_hit[IDX_CTRL]) begin
         ctrl_q <= wdata_i;
      end
   end
   assign ctrl_o = ctrl_q;

   assign tx_wr_o   = wr_hit[IDX_TXPUSH];
   assign tx_data_o = wdata_i[BYTE_W-1:0];

   assign word_val[IDX_STATE]  = DW'(state_q);
   assign word_val[IDX_ENABLE] = DW'(enable_q);
   assign word_val[IDX_TEST]   = '0;
   assign word_val[IDX_CTRL]   = ctrl_q;
   assign word_val[IDX_STATUS] = DW'(status_q);
   assign word_val[IDX_RBYTE]  = DW'(rbyte_q);
   assign word_val[IDX_TXPUSH] = '0;
   assign word_val[IDX_LINE]   = DW'(line_i);

   always_comb begin
      rd_val = '0;
      for (int k = 0; k < NUM_WORDS; k++) begin
         if (rd_hit[k]) begin
            rd_val = rd_val | word_val[k];
         end
      end
   end

   if (READ_REG) begin : g_rd_reg
      logic [DW-1:0] rdata_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rdata_q <= '0;
         end else if (rd_req) begin
            rdata_q <= rd_val;
         end
      end
      assign rdata_o = rdata_q;
   end else begin : g_rd_comb
      assign rdata_o = rd_req ? rd_val : '0;
   end
endmodule

// File: rtl/uart_irq_regs_chk.sv
`timescale 1ns/1ps
module uart_irq_regs_chk #(
   parameter int unsigned AW      = 10,
   parameter int unsigned DW      = 32,
   parameter int unsigned NUM_IRQ = 4,
   parameter int unsigned STAT_W  = 6,
   parameter int unsigned BYTE_W  = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               req_i,
   input logic               we_i,
   input logic [DW/8-1:0]    be_i,
   input logic [AW-1:0]      addr_i,
   input logic [NUM_IRQ-1:0] wlow_i,
   input logic [NUM_IRQ-1:0] evt_i,
   input logic               rx_valid_i,
   input logic [STAT_W-3:0]  hw_stat_i,
   input logic [NUM_IRQ-1:0] irq_o,
   input logic               tx_wr_o,
   input logic [NUM_IRQ-1:0] state_q,
   input logic [STAT_W-1:0]  status_q,
   input logic [BYTE_W-1:0]  rbyte_q,
   input logic               rx_on
);
   localparam int unsigned HW_W = STAT_W - 2;

   logic          wr_ok;
   logic [AW-3:0] widx;
   assign wr_ok = req_i && we_i && (be_i == '1) && (addr_i[1:0] == 2'b00);
   assign widx  = addr_i[AW-1:2];

   AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && widx == 1 && wlow_i == '0) |=> (irq_o == '0)); // R2

   AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && widx == 0 && evt_i == '0) |=> ((state_q & $past(wlow_i)) == '0)); // R3

   AST_TEST_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && widx == 2) |=> ((state_q & $past(wlow_i)) == $past(wlow_i))); // R4

   AST_HW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i != '0) |=> ((state_q & $past(evt_i)) == $past(evt_i))); // R5

   AST_RX_CLEARS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_valid_i && rx_on) |=> (status_q[STAT_W-1:HW_W] == 2'b00)); // R6

   AST_RBYTE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && widx == 5 && !rx_valid_i) |=> $stable(rbyte_q)); // R8

   AST_BAD_BE_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && be_i != '1) |-> !tx_wr_o); // R9

   AST_STATUS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (status_q[HW_W-1:0] == $past(hw_stat_i))); // R10
endmodule

bind uart_irq_regs uart_irq_regs_chk #(
   .AW      (AW),
   .DW      (DW),
   .NUM_IRQ (NUM_IRQ),
   .STAT_W  (STAT_W),
   .BYTE_W  (BYTE_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .req_i      (req_i),
   .we_i       (we_i),
   .be_i       (be_i),
   .addr_i     (addr_i),
   .wlow_i     (wdata_i[NUM_IRQ-1:0]),
   .evt_i      (evt_i),
   .rx_valid_i (rx_valid_i),
   .hw_stat_i  (hw_stat_i),
   .irq_o      (irq_o),
   .tx_wr_o    (tx_wr_o),
   .state_q    (state_q),
   .status_q   (status_q),
   .rbyte_q    (rbyte_q),
   .rx_on      (ctrl_q[1])
);

// File: tb/uart_irq_regs_tb.sv
`timescale 1ns/1ps
module uart_irq_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [3:0]  be = 4'hF;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  evt = '0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic [3:0]  hw_stat = 4'b1100;
   logic [1:0]  line = 2'b00;
   logic [3:0]  irq;
   logic [31:0] ctrl;
   logic        tx_wr;
   logic [7:0]  tx_data;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   uart_irq_regs u_dut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
      .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .hw_stat_i(hw_stat),
      .line_i(line), .irq_o(irq), .ctrl_o(ctrl), .tx_wr_o(tx_wr),
      .tx_data_o(tx_data)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [3:0]  m_state, m_en;
   logic [31:0] m_ctrl, m_rb, m_rdo, m_v;
   logic [5:0]  m_stat;
   logic        m_ok, m_rx_on;
   int          m_w;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_en = 0; m_ctrl = 0; m_stat = 6'h3C; m_rb = 0; m_rdo = 0;
      end else begin
         m_ok    = req && be == 4'hF && addr[1:0] == 2'b00;
         m_w     = int'(addr[9:2]);
         m_rx_on = m_ctrl[1];
         if (req && !we) begin
            m_v = 0;
            if (m_ok) begin
               case (m_w)
                  0: m_v = {28'd0, m_state};
                  1: m_v = {28'd0, m_en};
                  3: m_v = m_ctrl;
                  4: m_v = {26'd0, m_stat};
                  5: m_v = m_rb;
                  7: m_v = {30'd0, line};
                  default: m_v = 0;
               endcase
            end
            m_rdo = m_v;
         end
         if (m_ok && we && m_w == 0) m_state = m_state & ~wdata[3:0];
         if (m_ok && we && m_w == 2) m_state = m_state | wdata[3:0];
         m_state = m_state | evt;
         if (m_ok && we && m_w == 1) m_en = wdata[3:0];
         if (m_ok && we && m_w == 3) m_ctrl = wdata;
         m_stat[3:0] = hw_stat;
         if (m_rx_on && rx_valid) begin
            m_rb = {24'd0, rx_byte};
            m_stat[5:4] = 2'b00;
         end else if (m_rx_on && m_ok && !we && m_w == 5) begin
            m_stat[5:4] = 2'b11;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic exp_push;
         exp_push = req && we && be == 4'hF && addr == 10'd24;
         check({28'd0, irq}, {28'd0, m_state & m_en}, "R2 irq lines vs model");
         check(rdata, m_rdo, "R11 read data vs model");
         check(ctrl, m_ctrl, "R12 control output vs model");
         check({31'd0, tx_wr}, {31'd0, exp_push}, "R8 push strobe vs model");
         if (exp_push) check({24'd0, tx_data}, {24'd0, wdata[7:0]}, "R8 push byte vs model");
      end
   end

   // ---------------- stimulus tasks (called at posedge + 2) ----------------
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] b);
      req = 1; we = 1; addr = a; wdata = d; be = b;
      tick(1);
      req = 0; we = 0; be = 4'hF;
   endtask

   task automatic rd(input logic [9:0] a, input logic [3:0] b, input logic [31:0] exp, input string tag);
      req = 1; we = 0; addr = a; be = b;
      tick(1);
      req = 0; be = 4'hF;
      @(negedge clk);
      check(rdata, exp, tag);
      tick(1);
   endtask

   task automatic rx(input logic [7:0] byt);
      rx_valid = 1; rx_byte = byt;
      tick(1);
      rx_valid = 0;
   endtask

   initial begin
      #1;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset values
      rd(10'd16, 4'hF, 32'h3C, "R1 status reset");
      rd(10'd0,  4'hF, 32'h0,  "R1 state reset");
      rd(10'd4,  4'hF, 32'h0,  "R1 enable reset");
      rd(10'd12, 4'hF, 32'h0,  "R1 control reset");
      rd(10'd20, 4'hF, 32'h0,  "R1 received byte reset");
      check({28'd0, irq}, 32'h0, "R1 irq reset");

      // R4 test register sets, R2 lines follow
      wr(10'd4, 32'hF, 4'hF);
      wr(10'd8, 32'h5, 4'hF);
      rd(10'd0, 4'hF, 32'h5, "R4 test sets state");
      check({28'd0, irq}, 32'h5, "R2 irq equals state and enable");
      rd(10'd8, 4'hF, 32'h0, "R4 test reads zero");

      // R3 write-one-to-clear
      wr(10'd0, 32'h1, 4'hF);
      rd(10'd0, 4'hF, 32'h4, "R3 clear only ones");

      // R5 hardware set outranks a same-cycle clear
      evt = 4'h2;
      wr(10'd0, 32'h6, 4'hF);
      evt = 4'h0;
      rd(10'd0, 4'hF, 32'h2, "R5 event beats clear");
      wr(10'd0, 32'h2, 4'hF);
      rd(10'd0, 4'hF, 32'h0, "R3 clear after event");

      // R6 receive disabled: byte ignored
      rx(8'hA5);
      rd(10'd16, 4'hF, 32'h3C, "R6 status unchanged while rx off");
      rd(10'd20, 4'hF, 32'h0,  "R6 byte ignored while rx off");

      // R12 control, R6 receive enabled
      wr(10'd12, 32'hABCD_0003, 4'hF);
      rd(10'd12, 4'hF, 32'hABCD_0003, "R12 control readback");
      rx(8'h5A);
      rd(10'd16, 4'hF, 32'h0C, "R6 arrival clears idle and empty");
      rd(10'd20, 4'hF, 32'h5A, "R11 received byte read");
      rd(10'd16, 4'hF, 32'h3C, "R7 read re-arms flags");

      // R7 arrival in the same cycle as the read wins
      rx(8'h77);
      rx_valid = 1; rx_byte = 8'h33;
      rd(10'd20, 4'hF, 32'h77, "R7 read returns older byte");
      rx_valid = 0;
      rd(10'd16, 4'hF, 32'h0C, "R7 arrival beats re-arm");
      rd(10'd20, 4'hF, 32'h33, "R7 newer byte stored");
      rd(10'd16, 4'hF, 32'h3C, "R7 flags set after plain read");

      // R7 read with receive disabled leaves flags
      rx(8'h11);
      wr(10'd12, 32'h1, 4'hF);
      rd(10'd20, 4'hF, 32'h11, "R7 byte read while rx off");
      rd(10'd16, 4'hF, 32'h0C, "R7 no re-arm while rx off");

      // R8 read-only words and push word
      wr(10'd16, 32'h0, 4'hF);
      rd(10'd16, 4'hF, 32'h0C, "R8 status write ignored");
      wr(10'd20, 32'hFF, 4'hF);
      rd(10'd20, 4'hF, 32'h11, "R8 byte write ignored");
      line = 2'b10;
      wr(10'd28, 32'h1, 4'hF);
      rd(10'd28, 4'hF, 32'h2, "R8 line value read");
      req = 1; we = 1; addr = 10'd24; wdata = 32'h1234_56C3;
      @(negedge clk);
      check({31'd0, tx_wr}, 32'h1, "R8 push strobe");
      check({24'd0, tx_data}, 32'hC3, "R8 push byte");
      tick(1);
      req = 0; we = 0;
      rd(10'd24, 4'hF, 32'h0, "R8 push word reads zero");

      // R9 rejected accesses
      wr(10'd4, 32'h0, 4'h3);
      rd(10'd4, 4'hF, 32'hF, "R9 partial byte enable write dropped");
      wr(10'd5, 32'h0, 4'hF);
      rd(10'd4, 4'hF, 32'hF, "R9 misaligned write dropped");
      rd(10'd16, 4'h1, 32'h0, "R9 partial read gives zero");
      rd(10'd256, 4'hF, 32'h0, "R9 unmapped index gives zero");

      // R10 status low bits follow inputs
      hw_stat = 4'b0011;
      tick(1);
      rd(10'd16, 4'hF, 32'h03, "R10 hardware flags copied");
      hw_stat = 4'b1100;

      // R2 masking
      wr(10'd4, 32'h0, 4'hF);
      evt = 4'hF;
      tick(1);
      evt = 4'h0;
      rd(10'd0, 4'hF, 32'hF, "R2 state set by events");
      check({28'd0, irq}, 32'h0, "R2 masked lines low");
      wr(10'd4, 32'h9, 4'hF);
      @(negedge clk);
      check({28'd0, irq}, 32'h9, "R2 enabled lines high");
      tick(2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule